// File: doc/BRIEF.md
# Password-guarded GPIO pin register file

This block is the register file of a GPIO controller with up to eight banks of 32 pins. Software reaches it through a single-cycle word-addressed read/write port. It keeps one output latch per pin, which software changes through write-one-to-set and write-one-to-clear words. Each pin has a control word whose bit 0 picks the pin's direction. The block brings out the output level and the output enable toward the pads, and it samples the pad levels through a synchronizer so that software can read them back.

Each bank has a lock word. A set bit in it freezes that pin's control word and the pin's bits in the set and clear words. The lock word itself can change only through a two-step sequence. First a fixed password goes to a guard word, and then the very next bus write goes to the lock word. Any other write in between cancels the sequence. After reset every pin is an input, every output is low and every pin is locked.

Top module: `gpio_guarded_regs`

## Requirements
- R1: After reset all output latches are 0, pin_oe is 0, every control word reads 1 (input) and every lock word reads 0xFFFFFFFF.
- R2: A read request issued in one cycle presents its word on bus_rdata in the next cycle. In any cycle after a cycle without a read request, bus_rdata is 0. Interrupt words (0x080, 0x0A0, 0x0C0 + 4*bank), the set and clear words, the guard word and unmapped addresses read as 0.
- R3: Writing to the set word at 0x040 + 4*bank sets the output latch of every unlocked pin whose data bit is 1. Zero bits leave the latch as it is. The latch reads back at 0x000 + 4*bank and drives pin_out.
- R4: Writing to the clear word at 0x060 + 4*bank clears the output latch of every unlocked pin whose data bit is 1. Zero bits leave the latch as it is.
- R5: The control word of pin n sits at 0x100 + 4*n and holds CTRL_W bits. Bit 0 = 1 makes the pin an input and bit 0 = 0 makes it an output. pin_oe[n] is the inverse of bit 0. pin_oe and pin_out change only after a bus write.
- R6: While lock bit n is set, writes to pin n's control word, set bit and clear bit have no effect.
- R7: A write to the lock word at 0x500 + 4*bank replaces that bank's lock bits with the data only when the previous bus write was 0x00A5A501 to the guard word at 0x520. All zeros unlocks the bank and all ones locks it.
- R8: Any bus write other than the password to 0x520 disarms the guard. This includes a wrong password, a write to another address, and the lock write itself. Reads do not disarm it.
- R9: The input status word at 0x020 + 4*bank shows pin_in after SYNC_STAGES clock edges of synchronization.
- R10: The level word at 0x0E0 + 4*bank shows, for each pin, the synchronized input when the pin is an input and the output latch when it is an output.
- R11: Pin n maps to bank n>>5, bit n&31. Accesses to a bank index at or above NUM_BANKS, and addresses with nonzero low two bits, are ignored by writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pin_in | input | NUM_BANKS*32 | Pad levels |
| pin_out | output | NUM_BANKS*32 | Output latches toward the pads |
| pin_oe | output | NUM_BANKS*32 | Output enables (1 = drive) |

## Verification
Writes land on the clock edge that sees them, so the bench checks pin_out, pin_oe and the lock state at the falling edge right after that edge. Read data is due one edge after the request. The driver queues the expected word when it issues a read, and the monitor pops and compares it at the falling edge after the capturing edge. Input status lags pin_in by SYNC_STAGES edges: one read issued together with a pin change expects the old value, and the bench waits several cycles before expecting the new one. Guard sequences put writes, reads and idle cycles between the password and the lock write, and each lock outcome is checked by reading the lock word.

// File: rtl/gpio_guard_pkg.sv
package gpio_guard_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int BANK_PINS = 32;

    localparam logic [DATA_W-1:0] GUARD_KEY  = 32'h00A5A501;
    localparam logic [ADDR_W-1:0] GUARD_ADDR = 12'h520;
    localparam logic [ADDR_W-1:0] CTRL_BASE  = 12'h100;
    localparam logic [ADDR_W-1:0] LOCK_BASE  = 12'h500;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_OUT_STAT,
        RG_IN_STAT,
        RG_SET,
        RG_CLR,
        RG_IRQ_STAT,
        RG_IRQ_MASK,
        RG_IRQ_UNMASK,
        RG_LEVEL,
        RG_CTRL,
        RG_LOCK,
        RG_GUARD
    } region_e;

    // Region of a bank word in the low 256 bytes, by address bits [7:5].
    function automatic region_e bank_group(input logic [2:0] grp);
        case (grp)
            3'd0:    return RG_OUT_STAT;
            3'd1:    return RG_IN_STAT;
            3'd2:    return RG_SET;
            3'd3:    return RG_CLR;
            3'd4:    return RG_IRQ_STAT;
            3'd5:    return RG_IRQ_MASK;
            3'd6:    return RG_IRQ_UNMASK;
            default: return RG_LEVEL;
        endcase
    endfunction

endpackage

// File: rtl/gpio_guard_decode.sv
module gpio_guard_decode
    import gpio_guard_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_IW   = 1,
    parameter int PIN_IW    = 6
) (
    input  logic [ADDR_W-1:0]  addr,
    output region_e            region,
    output logic [BANK_IW-1:0] bank_idx,
    output logic [PIN_IW-1:0]  pin_idx
);
    localparam int          NUM_PINS = NUM_BANKS * BANK_PINS;
    localparam logic [3:0]  NB       = 4'(NUM_BANKS);
    localparam logic [12:0] CTRL_END = 13'(256 + 4 * NUM_PINS);

    logic              bank_ok;
    logic [ADDR_W-1:0] ctrl_off;

    assign bank_ok  = ({1'b0, addr[4:2]} < NB);
    assign ctrl_off = addr - CTRL_BASE;

    always_comb begin
        region   = RG_NONE;
        bank_idx = BANK_IW'(addr[4:2]);
        pin_idx  = PIN_IW'(ctrl_off >> 2);
        if (addr[1:0] == 2'b00) begin
            if (addr < CTRL_BASE) begin
                if (bank_ok) region = bank_group(addr[7:5]);
            end else if ({1'b0, addr} < CTRL_END) begin
                region = RG_CTRL;
            end else if (addr >= LOCK_BASE && addr < GUARD_ADDR) begin
                if (bank_ok) region = RG_LOCK;
            end else if (addr == GUARD_ADDR) begin
                region = RG_GUARD;
            end
        end
    end

endmodule

// File: rtl/gpio_guard_lock.sv
module gpio_guard_lock
    import gpio_guard_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_IW   = 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  region_e                        region,
    input  logic [BANK_IW-1:0]             bank_idx,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_BANKS*BANK_PINS-1:0] lock_bits,
    output logic                           armed
);
    logic [NUM_BANKS-1:0][BANK_PINS-1:0] lock_q;
    logic                                armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= '1;
            armed_q <= 1'b0;
        end else if (wr_en) begin
            // Every write consumes the arming; only the key re-arms.
            armed_q <= (region == RG_GUARD) && (wdata == GUARD_KEY);
            if (region == RG_LOCK && armed_q)
                lock_q[bank_idx] <= wdata;
        end
    end

    assign lock_bits = lock_q;
    assign armed     = armed_q;

endmodule

// File: rtl/gpio_guard_sync.sv
module gpio_guard_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q[0] <= d;
            for (int i = 1; i < STAGES; i++)
                st_q[i] <= st_q[i-1];
        end
    end

    assign q = st_q[STAGES-1];

endmodule

// File: rtl/gpio_guard_pins.sv
module gpio_guard_pins
    import gpio_guard_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_IW   = 1,
    parameter int PIN_IW    = 6,
    parameter int CTRL_W    = 9
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  region_e                        region,
    input  logic [BANK_IW-1:0]             bank_idx,
    input  logic [PIN_IW-1:0]              pin_idx,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NUM_BANKS*BANK_PINS-1:0] lock_bits,
    output logic [NUM_BANKS*BANK_PINS-1:0] out_bits,
    output logic [NUM_BANKS*BANK_PINS-1:0] dir_in,
    output logic [CTRL_W-1:0]              ctrl_rd
);
    localparam int                NUM_PINS = NUM_BANKS * BANK_PINS;
    localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1);

    logic [NUM_BANKS-1:0][BANK_PINS-1:0] out_q;
    logic [NUM_BANKS-1:0][BANK_PINS-1:0] lock_bank;
    logic [BANK_PINS-1:0]                hit_mask;
    logic [CTRL_W-1:0]                   ctrl_q [NUM_PINS];

    assign lock_bank = lock_bits;
    assign hit_mask  = wdata & ~lock_bank[bank_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            for (int p = 0; p < NUM_PINS; p++)
                ctrl_q[p] <= CTRL_RST;
        end else if (wr_en) begin
            case (region)
                RG_SET:  out_q[bank_idx] <= out_q[bank_idx] | hit_mask;
                RG_CLR:  out_q[bank_idx] <= out_q[bank_idx] & ~hit_mask;
                RG_CTRL: if (!lock_bits[pin_idx])
                             ctrl_q[pin_idx] <= wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_dir
        assign dir_in[p] = ctrl_q[p][0];
    end

    assign out_bits = out_q;
    assign ctrl_rd  = ctrl_q[pin_idx];

endmodule

// File: rtl/gpio_guarded_regs.sv
module gpio_guarded_regs
    import gpio_guard_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int CTRL_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_en,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_BANKS*BANK_PINS-1:0] pin_in,
    output logic [NUM_BANKS*BANK_PINS-1:0] pin_out,
    output logic [NUM_BANKS*BANK_PINS-1:0] pin_oe
);
    localparam int NUM_PINS = NUM_BANKS * BANK_PINS;
    localparam int BANK_IW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int PIN_IW   = $clog2(NUM_PINS);

    region_e             region;
    logic [BANK_IW-1:0]  bank_idx;
    logic [PIN_IW-1:0]   pin_idx;
    logic                wr_en;
    logic                rd_en;
    logic                lock_armed;
    logic [NUM_PINS-1:0] lock_bits;
    logic [NUM_PINS-1:0] out_bits;
    logic [NUM_PINS-1:0] dir_in;
    logic [NUM_PINS-1:0] in_sync;
    logic [NUM_PINS-1:0] level;
    logic [CTRL_W-1:0]   ctrl_rd;
    logic [DATA_W-1:0]   rdata_q;

    logic [NUM_BANKS-1:0][BANK_PINS-1:0] out_bank, in_bank, lvl_bank, lock_bank;

    assign wr_en = bus_en && bus_we;
    assign rd_en = bus_en && !bus_we;

    gpio_guard_decode #(
        .NUM_BANKS(NUM_BANKS), .BANK_IW(BANK_IW), .PIN_IW(PIN_IW)
    ) u_decode (
        .addr(bus_addr), .region(region), .bank_idx(bank_idx), .pin_idx(pin_idx)
    );

    gpio_guard_lock #(
        .NUM_BANKS(NUM_BANKS), .BANK_IW(BANK_IW)
    ) u_lock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .region(region),
        .bank_idx(bank_idx), .wdata(bus_wdata),
        .lock_bits(lock_bits), .armed(lock_armed)
    );

    gpio_guard_pins #(
        .NUM_BANKS(NUM_BANKS), .BANK_IW(BANK_IW), .PIN_IW(PIN_IW), .CTRL_W(CTRL_W)
    ) u_pins (
        .clk(clk), .rst(rst), .wr_en(wr_en), .region(region),
        .bank_idx(bank_idx), .pin_idx(pin_idx), .wdata(bus_wdata),
        .lock_bits(lock_bits), .out_bits(out_bits), .dir_in(dir_in),
        .ctrl_rd(ctrl_rd)
    );

    gpio_guard_sync #(
        .WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(in_sync)
    );

    assign level     = (in_sync & dir_in) | (out_bits & ~dir_in);
    assign out_bank  = out_bits;
    assign in_bank   = in_sync;
    assign lvl_bank  = level;
    assign lock_bank = lock_bits;

    always_ff @(posedge clk) begin
        if (rst || !rd_en) begin
            rdata_q <= '0;
        end else begin
            case (region)
                RG_OUT_STAT: rdata_q <= out_bank[bank_idx];
                RG_IN_STAT:  rdata_q <= in_bank[bank_idx];
                RG_LEVEL:    rdata_q <= lvl_bank[bank_idx];
                RG_CTRL:     rdata_q <= DATA_W'(ctrl_rd);
                RG_LOCK:     rdata_q <= lock_bank[bank_idx];
                default:     rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = out_bits;
    assign pin_oe    = ~dir_in;

endmodule

// File: rtl/gpio_guarded_regs_chk.sv
module gpio_guarded_regs_chk
    import gpio_guard_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_en,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] lock_bits,
    input logic                lock_armed
);
    logic key_write;
    assign key_write = bus_en && bus_we && bus_addr == GUARD_ADDR && bus_wdata == GUARD_KEY;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_out == '0 && pin_oe == '0 && lock_bits == '1 && !lock_armed));

    assert_idle_rdata_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && !bus_we) |=> bus_rdata == '0);

    assert_pins_need_write_R5: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && bus_we) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_locked_pins_hold_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pin_out ^ $past(pin_out)) | (pin_oe ^ $past(pin_oe)))
                  & $past(lock_bits)) == '0);

    assert_lock_needs_arm_R7: assert property (@(posedge clk) disable iff (rst)
        !lock_armed |=> $stable(lock_bits));

    assert_key_arms_R8: assert property (@(posedge clk) disable iff (rst)
        key_write |=> lock_armed);

    assert_other_write_disarms_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && !key_write) |=> !lock_armed);

endmodule

bind gpio_guarded_regs gpio_guarded_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .lock_bits(lock_bits),
    .lock_armed(lock_armed)
);

// File: tb/gpio_guarded_regs_tb_top.sv
module gpio_guarded_regs_tb_top;

    localparam int NB = 2;
    localparam int NP = NB * 32;
    localparam logic [31:0] KEY = 32'h00A5A501;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    logic     rd_seen = 1'b0;

    always #4 clk = ~clk;

    gpio_guarded_regs #(.NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Monitor: a read captured at a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_seen <= !rst && bus_en && !bus_we;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R2: read data with empty scoreboard, actual %h expected none", bus_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: read actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_out", pin_out, '0);
        chk("R1 pin_oe", pin_oe, '0);
        rd(12'h500, 32'hFFFFFFFF, "R1 lock bank0");
        rd(12'h504, 32'hFFFFFFFF, "R1 lock bank1");
        rd(12'h114, 32'h1, "R1 ctrl pin5");
        @(negedge clk);
        chk("R2 idle rdata", {32'h0, bus_rdata}, '0);

        // R6 locked pins ignore set and control writes
        wr(12'h040, 32'h000000FF);
        chk("R6 set while locked", pin_out, '0);
        wr(12'h100, 32'h0);
        chk("R6 ctrl while locked", pin_oe, '0);

        // R7 lock write without key
        wr(12'h500, 32'h0);
        rd(12'h500, 32'hFFFFFFFF, "R7 no key");

        // R8 intervening write, wrong key
        wr(12'h520, KEY);
        wr(12'h040, 32'h1);
        wr(12'h500, 32'h0);
        rd(12'h500, 32'hFFFFFFFF, "R8 intervening write");
        wr(12'h520, 32'h12345678);
        wr(12'h500, 32'h0);
        rd(12'h500, 32'hFFFFFFFF, "R8 wrong key");

        // R8 a read in between keeps the arming; R7 partial unlock
        wr(12'h520, KEY);
        rd(12'h000, 32'h0, "R8 read while armed");
        wr(12'h500, 32'hFFFF0000);
        rd(12'h500, 32'hFFFF0000, "R7 partial unlock");
        wr(12'h500, 32'h0);
        rd(12'h500, 32'hFFFF0000, "R8 arming used up");

        // R7 and R11 full unlock of bank1
        wr(12'h520, KEY);
        wr(12'h504, 32'h0);
        rd(12'h504, 32'h0, "R7 bank1 unlocked");

        // R3 set with partial lock
        wr(12'h040, 32'hFFFFFFFF);
        chk("R3 set bank0", pin_out, 64'h00000000_0000FFFF);
        rd(12'h000, 32'h0000FFFF, "R3 out status bank0");
        // R4 clear, zero bits untouched
        wr(12'h060, 32'h000000F0);
        chk("R4 clear bank0", pin_out, 64'h00000000_0000FF0F);
        // R11 bank1 offsets
        wr(12'h044, 32'h80000001);
        chk("R11 set bank1", pin_out, 64'h80000001_0000FF0F);
        rd(12'h004, 32'h80000001, "R11 out status bank1");
        wr(12'h064, 32'h00000001);
        chk("R4 clear bank1", pin_out, 64'h80000000_0000FF0F);

        // R5 control words
        wr(12'h10C, 32'h000003A6);
        rd(12'h10C, 32'h000001A6, "R5 ctrl readback pin3");
        chk("R5 oe pin3", pin_oe, 64'h00000000_00000008);
        wr(12'h150, 32'h0);
        rd(12'h150, 32'h1, "R6 ctrl pin20 locked");
        wr(12'h1FC, 32'h0);
        chk("R11 oe pin63", pin_oe, 64'h80000000_00000008);

        // R9 input synchronizer lag
        @(negedge clk);
        pin_in = 64'h00000000_00000005;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 12'h020;
        begin
            sb_item_t it;
            it.exp = 32'h0; it.tag = "R9 input not yet through";
            sb_q.push_back(it);
        end
        @(negedge clk);
        bus_en = 1'b0;
        repeat (4) @(negedge clk);
        rd(12'h020, 32'h00000005, "R9 input status bank0");
        // R10 level view
        rd(12'h0E0, 32'h0000000D, "R10 level bank0");
        rd(12'h0E4, 32'h80000000, "R10 level bank1");

        // R2 zero-reading words, R11 out-of-range and misaligned
        rd(12'h080, 32'h0, "R2 irq status");
        rd(12'h0A0, 32'h0, "R2 irq mask");
        rd(12'h040, 32'h0, "R2 set word");
        rd(12'h520, 32'h0, "R2 guard word");
        rd(12'h008, 32'h0, "R11 bank2 read");
        wr(12'h048, 32'hFFFFFFFF);
        wr(12'h041, 32'hFFFFFFFF);
        chk("R11 ignored writes", pin_out, 64'h80000000_0000FF0F);

        // R7 relock all, R6 clear and ctrl then ignored
        wr(12'h520, KEY);
        wr(12'h500, 32'hFFFFFFFF);
        rd(12'h500, 32'hFFFFFFFF, "R7 relock");
        wr(12'h060, 32'hFFFFFFFF);
        chk("R6 clear while locked", pin_out, 64'h80000000_0000FF0F);
        wr(12'h10C, 32'h1);
        chk("R6 ctrl pin3 locked", pin_oe, 64'h80000000_00000008);

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d reads never answered, actual %0d expected 0", sb_q.size(), sb_q.size());
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not end, actual timeout expected completion");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule